// File: doc/BRIEF.md
# Cascading Secondary Interrupt Controller

This block collects a parameterised group of peripheral interrupt lines (32 by default) and merges them into one request for a primary interrupt controller. Software configures each line separately. It can be level or edge sensitive, and active-high/rising or active-low/falling. A line reaches the merged request only while its enable bit is set.

Software never writes the enable mask directly. It sets enable bits through one alias word and clears them through another, so several drivers can share the mask without a read-modify-write race. Edge events are caught in a per-line latch. Software acknowledges them by writing ones to an acknowledge word. A status word shows every enabled line that is currently requesting service, and the cascade output is high whenever that word is nonzero.

All lines pass through a two-stage synchronizer. A level line shows in status two clock edges after its input changes. An edge line shows one edge after that, when its latch captures the event. The register port is a plain synchronous bus: a word address, write data and a write strobe, with read data returned combinationally from the address. Word map:

| Address | Access | Function |
|---|---|---|
| 0 | read-only | enable mask |
| 1 | write-one-to-set | enable set alias |
| 2 | write-one-to-clear | enable clear alias |
| 3 | read/write | trigger kind, 1 = edge, 0 = level |
| 4 | read/write | sense, 1 = low/falling, 0 = high/rising |
| 5 | write-one | edge acknowledge |
| 6 | read-only | pending status |

Addresses 1, 2, 5 and 7 read as zero.

Top module: `sic_top`

## Requirements
- R1: After reset the enable, trigger-kind and sense words read zero, the status word reads zero and the cascade output is low while all lines are low.
- R2: Writing a mask to address 1 sets every enable bit that is one in the mask and leaves every other enable bit unchanged.
- R3: Writing a mask to address 2 clears every enable bit that is one in the mask and leaves every other enable bit unchanged.
- R4: A write to address 0 is ignored: the enable word reads back unchanged afterwards.
- R5: The trigger-kind word (address 3) and the sense word (address 4) read back what was written. In every word, bits at or above the source count read as zero.
- R6: An enabled level line with sense 0 shows in status bit i while its input is high and drops out when its input goes low.
- R7: An enabled level line with sense 1 shows in status while its input is low.
- R8: An enabled edge line with sense 0 becomes pending on a rising input edge and stays pending after the input falls, until it is acknowledged.
- R9: An edge line with sense 1 becomes pending on a falling edge only; a rising edge does not set it.
- R10: Writing ones to address 5 clears the edge latch of exactly those lines; other pending lines stay pending.
- R11: If an acknowledge of a line and a new active edge on that line fall in the same cycle, the line stays pending.
- R12: A disabled edge line still latches an edge without showing it in status; once the line is enabled the latched edge appears.
- R13: The cascade output is high exactly when the status word is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_SRC | Asynchronous peripheral interrupt lines |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| cascade_irq | output | 1 | Merged request to the primary controller |

## Verification
Some properties are checked on every cycle. Enable bits move only through the two aliases, and the set alias never clears a bit while the clear alias always does. An acknowledged latch with no fresh edge falls, and a fresh edge always sets the latch even under acknowledge. A latch never falls without an acknowledge. The cascade output agrees with the status word, and unused high bits stay zero.

Other behaviour can only be shown by the bench's scenarios. These are the polarity and trigger-kind decoding from the line pins through the synchronizer to status, the way falling-edge lines ignore rising edges, and the latched edge of a disabled line appearing once the line is enabled. The bench also lines up an acknowledge exactly with a synchronized edge to show that the edge wins.

// File: rtl/sic_pkg.sv
package sic_pkg;

    // Word addresses of the register port
    localparam int unsigned REG_EN   = 0;
    localparam int unsigned REG_SET  = 1;
    localparam int unsigned REG_CLR  = 2;
    localparam int unsigned REG_TRIG = 3;
    localparam int unsigned REG_POL  = 4;
    localparam int unsigned REG_ACK  = 5;
    localparam int unsigned REG_STAT = 6;

    // Minimum address width that reaches every word
    localparam int unsigned MIN_ADDR_W = 3;

endpackage

// File: rtl/sic_sync.sv
module sic_sync #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);

    typedef struct packed {
        logic [N-1:0] stage1;
        logic [N-1:0] stage2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.stage1 = async_in;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stage2;

endmodule

// File: rtl/sic_detect.sv
module sic_detect #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,      // synchronized line values
    input  logic [N-1:0] trig,     // 1 = edge
    input  logic [N-1:0] pol,      // 1 = low / falling
    input  logic [N-1:0] en,
    input  logic [N-1:0] ack,      // one-cycle acknowledge mask
    output logic [N-1:0] status
);

    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] latch;
    } det_st_t;

    det_st_t st_d, st_q;

    logic [N-1:0] act_lvl;
    logic [N-1:0] edge_ev;

    // Per-line sense decoding; the previous raw value keeps a sense
    // change from looking like an edge.
    for (genvar i = 0; i < N; i++) begin : g_line
        assign act_lvl[i] = lvl[i] ^ pol[i];
        assign edge_ev[i] = trig[i] &
                            (pol[i] ? (~lvl[i] &  st_q.prev[i])
                                    : ( lvl[i] & ~st_q.prev[i]));
    end

    always_comb begin
        st_d.prev  = lvl;
        // new edge has priority over acknowledge
        st_d.latch = (st_q.latch & ~ack) | edge_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = ((trig & st_q.latch) | (~trig & act_lvl)) & en;

    // R10: an acknowledged latch with no fresh edge is cleared
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.latch & $past(ack & ~edge_ev)) == '0));

    // R11: a fresh edge always leaves the latch set, even under acknowledge
    a_r11_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.latch & $past(edge_ev)) == $past(edge_ev)));

    // R8: a latch only falls when acknowledged
    a_r8_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q.latch) & ~$past(ack) & ~st_q.latch) == '0));

endmodule

// File: rtl/sic_regs.sv
module sic_regs
    import sic_pkg::*;
#(
    parameter int unsigned N      = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic [N-1:0]      status,
    output logic [DATA_W-1:0] rdata,
    output logic [N-1:0]      en,
    output logic [N-1:0]      trig,
    output logic [N-1:0]      pol,
    output logic [N-1:0]      ack
);

    typedef struct packed {
        logic [N-1:0] en;
        logic [N-1:0] trig;
        logic [N-1:0] pol;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    logic [N-1:0] wmask;
    logic [N-1:0] rsel;

    assign wmask = wdata[N-1:0];

    always_comb begin
        st_d = st_q;
        if (we) begin
            if (addr == ADDR_W'(REG_SET))  st_d.en   = st_q.en | wmask;
            if (addr == ADDR_W'(REG_CLR))  st_d.en   = st_q.en & ~wmask;
            if (addr == ADDR_W'(REG_TRIG)) st_d.trig = wmask;
            if (addr == ADDR_W'(REG_POL))  st_d.pol  = wmask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rsel = '0;
        if (addr == ADDR_W'(REG_EN))   rsel = st_q.en;
        if (addr == ADDR_W'(REG_TRIG)) rsel = st_q.trig;
        if (addr == ADDR_W'(REG_POL))  rsel = st_q.pol;
        if (addr == ADDR_W'(REG_STAT)) rsel = status;
    end

    assign rdata = DATA_W'(rsel);
    assign ack   = (we && addr == ADDR_W'(REG_ACK)) ? wmask : '0;
    assign en    = st_q.en;
    assign trig  = st_q.trig;
    assign pol   = st_q.pol;

    // R2: the set alias never drops an enable bit and raises every masked bit
    a_r2_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(REG_SET)) |=>
        ((($past(st_q.en) & ~st_q.en) == '0) &&
         ((st_q.en & $past(wmask)) == $past(wmask))));

    // R3: the clear alias drops every masked bit and raises none
    a_r3_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(REG_CLR)) |=>
        (((st_q.en & $past(wmask)) == '0) &&
         ((st_q.en & ~$past(st_q.en)) == '0)));

    // R4: enables move only through the two aliases
    a_r4_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && (addr == ADDR_W'(REG_SET) || addr == ADDR_W'(REG_CLR))) |=>
        $stable(st_q.en));

endmodule

// File: rtl/sic_top.sv
module sic_top
    import sic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = MIN_ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_we,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               cascade_irq
);

    logic [NUM_SRC-1:0] lvl_sync;
    logic [NUM_SRC-1:0] en, trig, pol, ack, status;

    sic_sync #(.N(NUM_SRC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (lvl_sync)
    );

    sic_regs #(.N(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .we     (bus_we),
        .status (status),
        .rdata  (bus_rdata),
        .en     (en),
        .trig   (trig),
        .pol    (pol),
        .ack    (ack)
    );

    sic_detect #(.N(NUM_SRC)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (lvl_sync),
        .trig   (trig),
        .pol    (pol),
        .en     (en),
        .ack    (ack),
        .status (status)
    );

    assign cascade_irq = |status;

    // R13: the merged request agrees with the status word seen on the bus
    a_r13_cascade: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(REG_STAT)) |-> (cascade_irq == (bus_rdata != '0)));

    if (NUM_SRC < DATA_W) begin : g_upper
        // R5: bits above the source count never read as one
        a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rdata[DATA_W-1:NUM_SRC] == '0);
    end

endmodule

// File: tb/tb_sic_top.sv
`timescale 1ns/1ps
module tb_sic_top;

    localparam int unsigned N  = 24;
    localparam int unsigned DW = 32;
    localparam int unsigned AW = 3;

    localparam logic [2:0] K_WR = 3'd0, K_RD = 3'd1, K_IRQ = 3'd2,
                           K_WAIT = 3'd3, K_CASC = 3'd4;

    typedef struct packed {
        logic [2:0]  kind;
        logic [2:0]  addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 44;
    localparam vec_t VECS [NV] = '{
        '{K_WR,   3'd3, 32'h0000_0F00, 8'd5},  // R5 lines 8..11 edge
        '{K_WR,   3'd4, 32'h0000_0AF0, 8'd5},  // R5 lines 4..7 low, 9,11 falling
        '{K_RD,   3'd3, 32'h0000_0F00, 8'd5},
        '{K_RD,   3'd4, 32'h0000_0AF0, 8'd5},
        '{K_WR,   3'd1, 32'h0000_000F, 8'd2},  // R2
        '{K_RD,   3'd0, 32'h0000_000F, 8'd2},
        '{K_WR,   3'd1, 32'h0000_0FF0, 8'd2},
        '{K_RD,   3'd0, 32'h0000_0FFF, 8'd2},
        '{K_WR,   3'd2, 32'h0000_0003, 8'd3},  // R3
        '{K_RD,   3'd0, 32'h0000_0FFC, 8'd3},
        '{K_WR,   3'd0, 32'hFFFF_FFFF, 8'd4},  // R4
        '{K_RD,   3'd0, 32'h0000_0FFC, 8'd4},
        '{K_WR,   3'd1, 32'h0000_0003, 8'd2},
        '{K_RD,   3'd0, 32'h0000_0FFF, 8'd2},
        '{K_WAIT, 3'd0, 32'd4,         8'd7},  // R7 low lines idle low
        '{K_RD,   3'd6, 32'h0000_00F0, 8'd7},
        '{K_CASC, 3'd0, 32'd1,         8'd13}, // R13
        '{K_IRQ,  3'd0, 32'h0000_00F3, 8'd6},  // R6
        '{K_WAIT, 3'd0, 32'd4,         8'd6},
        '{K_RD,   3'd6, 32'h0000_0003, 8'd6},
        '{K_IRQ,  3'd0, 32'h0000_00F0, 8'd6},
        '{K_WAIT, 3'd0, 32'd4,         8'd6},
        '{K_RD,   3'd6, 32'h0000_0000, 8'd6},
        '{K_CASC, 3'd0, 32'd0,         8'd13}, // R13
        '{K_IRQ,  3'd0, 32'h0000_01F0, 8'd8},  // R8 rise on 8
        '{K_WAIT, 3'd0, 32'd4,         8'd8},
        '{K_RD,   3'd6, 32'h0000_0100, 8'd8},
        '{K_IRQ,  3'd0, 32'h0000_00F0, 8'd8},
        '{K_WAIT, 3'd0, 32'd4,         8'd8},
        '{K_RD,   3'd6, 32'h0000_0100, 8'd8},
        '{K_IRQ,  3'd0, 32'h0000_0AF0, 8'd9},  // R9 rise ignored
        '{K_WAIT, 3'd0, 32'd4,         8'd9},
        '{K_RD,   3'd6, 32'h0000_0100, 8'd9},
        '{K_IRQ,  3'd0, 32'h0000_00F0, 8'd9},  // R9 fall latches
        '{K_WAIT, 3'd0, 32'd4,         8'd9},
        '{K_RD,   3'd6, 32'h0000_0B00, 8'd9},
        '{K_WR,   3'd5, 32'h0000_0100, 8'd10}, // R10 partial ack
        '{K_RD,   3'd6, 32'h0000_0A00, 8'd10},
        '{K_WR,   3'd5, 32'h0000_0A00, 8'd10},
        '{K_RD,   3'd6, 32'h0000_0000, 8'd10},
        '{K_WR,   3'd3, 32'hFFFF_FFFF, 8'd5},  // R5 upper bits
        '{K_RD,   3'd3, 32'h00FF_FFFF, 8'd5},
        '{K_WR,   3'd3, 32'h0000_0F00, 8'd5},
        '{K_RD,   3'd3, 32'h0000_0F00, 8'd5}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic          cascade_irq;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sic_top #(.NUM_SRC(N), .DATA_W(DW), .ADDR_W(AW)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_in      (irq_in),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_we      (bus_we),
        .bus_rdata   (bus_rdata),
        .cascade_irq (cascade_irq)
    );

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                          input string req);
        bus_addr = a;
        #1;
        n_run++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s addr %0d: got %h expected %h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic casc_chk(input logic exp, input string req);
        #1;
        n_run++;
        if (cascade_irq !== exp) begin
            n_fail++;
            $display("FAIL %s cascade: got %b expected %b", req, cascade_irq, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd_chk(3'd0, '0, "R1");
        rd_chk(3'd3, '0, "R1");
        rd_chk(3'd4, '0, "R1");
        rd_chk(3'd6, '0, "R1");
        casc_chk(1'b0, "R1");

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", VECS[i].req);
            case (VECS[i].kind)
                K_WR:   wr(VECS[i].addr, VECS[i].data);
                K_RD:   rd_chk(VECS[i].addr, VECS[i].data, rq);
                K_IRQ:  begin @(negedge clk); irq_in = VECS[i].data[N-1:0]; end
                K_WAIT: repeat (VECS[i].data) @(negedge clk);
                K_CASC: begin bus_addr = 3'd6; casc_chk(VECS[i].data[0], rq); end
                default: ;
            endcase
        end

        // R12: disabled line latches but hides the edge
        wr(3'd2, 32'h0000_0400);
        @(negedge clk); irq_in = 24'h0004F0;
        repeat (4) @(negedge clk);
        rd_chk(3'd6, 32'h0, "R12");
        wr(3'd1, 32'h0000_0400);
        rd_chk(3'd6, 32'h0000_0400, "R12");
        wr(3'd5, 32'h0000_0400);
        rd_chk(3'd6, 32'h0, "R10");

        // R11: latch line 8, drop it, then a new rise coincides with ack
        @(negedge clk); irq_in = 24'h0005F0;
        repeat (4) @(negedge clk);
        rd_chk(3'd6, 32'h0000_0100, "R8");
        @(negedge clk); irq_in = 24'h0004F0;
        repeat (4) @(negedge clk);
        @(negedge clk); irq_in = 24'h0005F0;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 3'd5; bus_wdata = 32'h0000_0100; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        rd_chk(3'd6, 32'h0000_0100, "R11");
        casc_chk(1'b1, "R13");
        wr(3'd5, 32'h0000_0100);
        rd_chk(3'd6, 32'h0, "R10");
        casc_chk(1'b0, "R13");

        finish_run();
    end

endmodule